// File: doc/BRIEF.md
# Compact Instruction Word Decoder

This block turns one 16-bit instruction word of a small 32-bit processor with sixteen general registers into the fields that the execute stage needs. It reports which of three encoding forms the word uses, an operation index within that form, the register indices, an 8-bit unsigned immediate, a 10-bit branch displacement field, whether a 32-bit extension word trails the instruction, the total instruction length in bytes, and whether the word is illegal.

The fetch unit presents a word with `in_valid` high; one clock later the decoded result appears with `out_valid` high. The block does not fetch the extension word, execute anything or hold registers. It only tells the fetch unit how many bytes to consume and the execute stage what to do. Two helper flags mark the no-operation word and the three shift operations, whose shift amount the execute stage must limit to its low five bits.

Top module: `insn_word_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output becomes zero on that edge.
- R2: `out_valid` equals `in_valid` of the previous cycle; `illegal` is never high while `out_valid` is low; with `in_valid` low all field outputs keep their previous values.
- R3: `form` is 1 when word bit 15 is 0, 2 when bits 15:14 are `10`, and 3 when bits 15:14 are `11`.
- R4: Form 1: `op_idx` is bits 14:8, `reg_a` bits 7:4, `reg_b` bits 3:0; `imm8` and `br_ofs` are zero.
- R5: Form 2: `op_idx` is bits 13:12 zero-extended (0 add immediate, 1 subtract immediate, 2 read special register, 3 write special register), `reg_a` is bits 11:8, `imm8` bits 7:0; `reg_b` and `br_ofs` are zero.
- R6: Form 3: `op_idx` is the condition code in bits 13:10 (0..9 in order: equal, not equal, signed less, signed greater, unsigned less, unsigned greater, signed greater-or-equal, signed less-or-equal, unsigned greater-or-equal, unsigned less-or-equal), `br_ofs` is bits 9:0; `reg_a`, `reg_b`, `imm8` are zero.
- R7: Form 1 is illegal unless bits 14:8 lie in 0x00..0x0E or 0x19..0x39.
- R8: Form 3 is illegal for condition codes 10..15; form 2 is never illegal.
- R9: `has_ext` is high and `len_bytes` is 6 exactly for legal form 1 words with bits 14:8 in {0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38, 0x39}; every other valid word reports `has_ext` low and `len_bytes` 2.
- R10: `is_nop` is high only for form 1 index 0x00, and `is_shift` only for form 1 indices 0x27, 0x28 and 0x2D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Word strobe |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| form | output | 2 | Encoding form (0 after reset, 1..3) |
| op_idx | output | 7 | Operation index within the form |
| reg_a | output | 4 | First register index |
| reg_b | output | 4 | Second register index |
| imm8 | output | 8 | Unsigned 8-bit immediate |
| br_ofs | output | 10 | Raw branch displacement field |
| has_ext | output | 1 | A 32-bit extension word follows |
| len_bytes | output | 3 | Instruction length in bytes |
| illegal | output | 1 | Illegal instruction, qualified by out_valid |
| is_nop | output | 1 | No-operation word |
| is_shift | output | 1 | Shift operation (amount uses low 5 bits) |

## Verification
Every one of the 65536 words is presented back to back, so each form, each index boundary of the legal ranges (0x0E/0x0F, 0x18/0x19, 0x39/0x3A) and each condition code 9/10 split is seen with all register and immediate bit patterns, which separates field-slicing errors from legality and length errors. A second pattern drops the strobe while an illegal word sits on the input, which tells a strobe-qualified illegal flag and held fields apart from a free-running decode. A reset in the middle of traffic shows that all outputs clear.

// File: rtl/insn_dec_pkg.sv
// Package: shared widths and the form encoding of the instruction decoder.
// Assumes a 16-bit instruction word and sixteen general registers.
package insn_dec_pkg;
    localparam int WORD_W  = 16;
    localparam int RIDX_W  = 4;
    localparam int IMM_W   = 8;
    localparam int OFS_W   = 10;
    localparam int OPIX_W  = 7;
    localparam int CC_W    = 4;
    localparam int LEN_W   = 3;
    localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
    localparam logic [LEN_W-1:0] LEN_LONG  = 3'd6;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_REG  = 2'd1,
        FORM_IMM  = 2'd2,
        FORM_BR   = 2'd3
    } form_t;

    typedef struct packed {
        form_t               form;
        logic [OPIX_W-1:0]   op_idx;
        logic [RIDX_W-1:0]   reg_a;
        logic [RIDX_W-1:0]   reg_b;
        logic [IMM_W-1:0]    imm8;
        logic [OFS_W-1:0]    br_ofs;
        logic                has_ext;
        logic [LEN_W-1:0]    len_bytes;
        logic                illegal;
        logic                is_nop;
        logic                is_shift;
    } dec_t;
endpackage

// File: rtl/regop_table.sv
// Attribute table for register-form operation indices: legality, trailing
// extension word, no-operation and shift class. Purely combinational.
// Assumes the index is the 7 bits below the form bit.
module regop_table
    import insn_dec_pkg::*;
#(
    parameter int LO_LAST   = 14,
    parameter int HI_FIRST  = 25,
    parameter int HI_LAST   = 57
) (
    input  logic [OPIX_W-1:0] idx,
    output logic              legal,
    output logic              long_fmt,
    output logic              nop,
    output logic              shift
);
    // Legal index ranges.
    always_comb begin
        legal = (int'(idx) <= LO_LAST) ||
                ((int'(idx) >= HI_FIRST) && (int'(idx) <= HI_LAST));
    end

    // Operations that carry a 32-bit word after the instruction.
    always_comb begin
        unique case (idx)
            7'h01, 7'h03, 7'h08, 7'h09, 7'h0c, 7'h0d,
            7'h1a, 7'h1b, 7'h1d, 7'h1f, 7'h20, 7'h22,
            7'h24, 7'h30, 7'h36, 7'h37, 7'h38, 7'h39: long_fmt = 1'b1;
            default:                                   long_fmt = 1'b0;
        endcase
    end

    // Class flags used by the execute stage.
    always_comb begin
        nop   = (idx == 7'h00);
        shift = (idx == 7'h27) || (idx == 7'h28) || (idx == 7'h2d);
    end
endmodule

// File: rtl/cond_check.sv
// Branch condition legality: codes below N_DEFINED are legal.
// Assumes a 4-bit condition field.
module cond_check
    import insn_dec_pkg::*;
#(
    parameter int N_DEFINED = 10
) (
    input  logic [CC_W-1:0] cc,
    output logic            legal
);
    // Compare the code against the count of defined conditions.
    always_comb legal = (int'(cc) < N_DEFINED);
endmodule

// File: rtl/insn_word_decoder.sv
// Top: splits a 16-bit instruction word by form, looks up attributes and
// registers the decoded result one cycle after the strobe.
// Assumes the fetch unit supplies one word per strobe; fields hold when idle.
module insn_word_decoder
    import insn_dec_pkg::*;
#(
    parameter int N_COND = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [1:0]        form,
    output logic [OPIX_W-1:0] op_idx,
    output logic [RIDX_W-1:0] reg_a,
    output logic [RIDX_W-1:0] reg_b,
    output logic [IMM_W-1:0]  imm8,
    output logic [OFS_W-1:0]  br_ofs,
    output logic              has_ext,
    output logic [LEN_W-1:0]  len_bytes,
    output logic              illegal,
    output logic              is_nop,
    output logic              is_shift
);
    logic rop_legal, rop_long, rop_nop, rop_shift;
    logic cc_legal;
    dec_t nxt, cur;
    logic vld_q;

    regop_table u_table (
        .idx      (in_word[WORD_W-2 -: OPIX_W]),
        .legal    (rop_legal),
        .long_fmt (rop_long),
        .nop      (rop_nop),
        .shift    (rop_shift)
    );

    cond_check #(.N_DEFINED(N_COND)) u_cc (
        .cc    (in_word[WORD_W-3 -: CC_W]),
        .legal (cc_legal)
    );

    // Build the decoded record for the current word.
    always_comb begin
        nxt = '0;
        nxt.len_bytes = LEN_SHORT;
        if (!in_word[WORD_W-1]) begin
            nxt.form     = FORM_REG;
            nxt.op_idx   = in_word[WORD_W-2 -: OPIX_W];
            nxt.reg_a    = in_word[2*RIDX_W-1 -: RIDX_W];
            nxt.reg_b    = in_word[RIDX_W-1:0];
            nxt.illegal  = !rop_legal;
            nxt.has_ext  = rop_legal && rop_long;
            nxt.is_nop   = rop_nop;
            nxt.is_shift = rop_shift;
            if (rop_legal && rop_long) nxt.len_bytes = LEN_LONG;
        end else if (!in_word[WORD_W-2]) begin
            nxt.form   = FORM_IMM;
            nxt.op_idx = OPIX_W'(in_word[WORD_W-3 -: 2]);
            nxt.reg_a  = in_word[IMM_W+RIDX_W-1 -: RIDX_W];
            nxt.imm8   = in_word[IMM_W-1:0];
        end else begin
            nxt.form    = FORM_BR;
            nxt.op_idx  = OPIX_W'(in_word[WORD_W-3 -: CC_W]);
            nxt.br_ofs  = in_word[OFS_W-1:0];
            nxt.illegal = !cc_legal;
        end
    end

    // Register the record on a strobe; clear the illegal flag when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) cur <= nxt;
            else          cur.illegal <= 1'b0;
        end
    end

    assign out_valid = vld_q;
    assign form      = cur.form;
    assign op_idx    = cur.op_idx;
    assign reg_a     = cur.reg_a;
    assign reg_b     = cur.reg_b;
    assign imm8      = cur.imm8;
    assign br_ofs    = cur.br_ofs;
    assign has_ext   = cur.has_ext;
    assign len_bytes = cur.len_bytes;
    assign illegal   = cur.illegal;
    assign is_nop    = cur.is_nop;
    assign is_shift  = cur.is_shift;
endmodule

// File: rtl/insn_word_decoder_chk.sv
// Checker: temporal properties of the decoder ports, bound to the top.
module insn_word_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] in_word,
    input logic        out_valid,
    input logic [1:0]  form,
    input logic [6:0]  op_idx,
    input logic [3:0]  reg_a,
    input logic [7:0]  imm8,
    input logic        has_ext,
    input logic [2:0]  len_bytes,
    input logic        illegal
);
    p_strobe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_illegal_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !illegal);
    p_hold_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(reg_a) && $stable(imm8) && $stable(op_idx)));
    p_form_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (form == ($past(in_word[15]) ? $past(in_word[15:14]) : 2'b01)));
    p_cond_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && form == 2'd3 && op_idx >= 7'd10) |-> illegal);
    p_imm_form_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && form == 2'd2) |-> !illegal);
    p_ext_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (has_ext == (len_bytes == 3'd6)));
    p_ext_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        has_ext |-> (!illegal && form == 2'd1));
endmodule

bind insn_word_decoder insn_word_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .form      (form),
    .op_idx    (op_idx),
    .reg_a     (reg_a),
    .imm8      (imm8),
    .has_ext   (has_ext),
    .len_bytes (len_bytes),
    .illegal   (illegal)
);

// File: tb/sim_insn_word_decoder.sv
module sim_insn_word_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_valid, has_ext, illegal, is_nop, is_shift;
    logic [1:0]  form;
    logic [6:0]  op_idx;
    logic [3:0]  reg_a, reg_b;
    logic [7:0]  imm8;
    logic [9:0]  br_ofs;
    logic [2:0]  len_bytes;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    insn_word_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .form(form), .op_idx(op_idx), .reg_a(reg_a),
        .reg_b(reg_b), .imm8(imm8), .br_ofs(br_ofs), .has_ext(has_ext),
        .len_bytes(len_bytes), .illegal(illegal), .is_nop(is_nop),
        .is_shift(is_shift)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s word=%04h actual=%0h expected=%0h", tag, in_word, act, exp);
        end
    endtask

    // Expected decode of one word, derived from the requirements.
    task automatic check_word(input logic [15:0] w);
        int e_form, e_op, e_ra, e_rb, e_imm, e_ofs, e_ext, e_len, e_ill, e_nop, e_sh;
        int ix;
        bit lng;
        e_ra = 0; e_rb = 0; e_imm = 0; e_ofs = 0; e_ext = 0; e_len = 2;
        e_ill = 0; e_nop = 0; e_sh = 0;
        if (w[15] == 1'b0) begin
            ix = w / 256;
            e_form = 1; e_op = ix; e_ra = (w / 16) % 16; e_rb = w % 16;
            e_ill = !((ix <= 14) || (ix >= 25 && ix <= 57)) ? 1 : 0;
            lng = (ix == 1) || (ix == 3) || (ix == 8) || (ix == 9) || (ix == 12) ||
                  (ix == 13) || (ix == 26) || (ix == 27) || (ix == 29) || (ix == 31) ||
                  (ix == 32) || (ix == 34) || (ix == 36) || (ix == 48) ||
                  (ix >= 54 && ix <= 57);
            if (lng) begin e_ext = 1; e_len = 6; end
            e_nop = (ix == 0) ? 1 : 0;
            e_sh  = (ix == 39 || ix == 40 || ix == 45) ? 1 : 0;
        end else if (w[14] == 1'b0) begin
            e_form = 2; e_op = (w / 4096) % 4; e_ra = (w / 256) % 16; e_imm = w % 256;
        end else begin
            e_form = 3; e_op = (w / 1024) % 16; e_ofs = w % 1024;
            e_ill = (e_op >= 10) ? 1 : 0;
        end
        chk("R2 out_valid", int'(out_valid), 1);
        chk("R3 form", int'(form), e_form);
        chk("R4/R5/R6 op_idx", int'(op_idx), e_op);
        chk("R4/R5 reg_a", int'(reg_a), e_ra);
        chk("R4 reg_b", int'(reg_b), e_rb);
        chk("R5 imm8", int'(imm8), e_imm);
        chk("R6 br_ofs", int'(br_ofs), e_ofs);
        chk(w[15] ? "R8 illegal" : "R7 illegal", int'(illegal), e_ill);
        chk("R9 has_ext", int'(has_ext), e_ext);
        chk("R9 len_bytes", int'(len_bytes), e_len);
        chk("R10 is_nop", int'(is_nop), e_nop);
        chk("R10 is_shift", int'(is_shift), e_sh);
    endtask

    initial begin
        // R1: reset state
        in_valid = 1'b1; in_word = 16'hffff;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 illegal", int'(illegal), 0);
        chk("R1 len_bytes", int'(len_bytes), 0);
        chk("R1 form", int'(form), 0);
        rst_n = 1'b1;
        // Exhaustive sweep, one word per cycle, checked a cycle later.
        in_word = 16'h0000; in_valid = 1'b1;
        for (int w = 0; w < 65536; w++) begin
            in_word = 16'(w);
            @(negedge clk);
            check_word(16'(w));
        end
        // R2: strobe low with an illegal word present: flag low, fields hold.
        in_word = 16'h4000; in_valid = 1'b1;
        @(negedge clk);
        chk("R2 setup illegal", int'(illegal), 1);
        in_valid = 1'b0; in_word = 16'hfc00;
        @(negedge clk);
        chk("R2 idle out_valid", int'(out_valid), 0);
        chk("R2 idle illegal", int'(illegal), 0);
        chk("R2 idle op_idx held", int'(op_idx), 'h40);
        chk("R2 idle form held", int'(form), 1);
        // R1: reset in the middle of traffic.
        in_valid = 1'b1; in_word = 16'h0112;
        @(negedge clk);
        chk("R9 mid len", int'(len_bytes), 6);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid out_valid", int'(out_valid), 0);
        chk("R1 mid len", int'(len_bytes), 0);
        chk("R1 mid reg_a", int'(reg_a), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule